// File: doc/BRIEF.md
# Shift-Add Coefficient Scaler

This block scales an unsigned pixel by a small signed integer coefficient without a hardware multiplier. It is one arithmetic unit inside an image pre-filter. The filter's two tuning parameters, sharpening strength and clamp strength, are set by the user to suit the picture. Their difference (or that difference minus one) becomes the coefficient, and the parameter logic hands that coefficient to this block as a 3-bit code and a negate flag.

A small decoder turns the code into the selects of three independent lanes. The low lane picks nothing or the pixel itself. The middle lane picks nothing or four times the pixel. The high lane picks nothing, eight times or sixteen times the pixel. Fixed shifts form these multiples. An adder tree sums the lanes, and the negate flag is applied as two's complement. A sign stage then turns the signed sum into a magnitude and a sign bit. One register stage follows, so each valid input yields a valid result one clock later.

Top module: `rcu_shift_add`

## Requirements
- R1: With `in_neg` low, codes 0 to 6 give the coefficients 1, 4, 5, 8, 9, 17 and 21. `out_mag` equals the coefficient times `in_pix`, and `out_neg` is 0.
- R2: With `in_neg` high, the product is negative. `out_mag` holds its absolute value, and `out_neg` is 1 exactly when that magnitude is nonzero, so a zero result always has `out_neg` at 0.
- R3: Code 7 is unsupported and gives `out_mag` = 0 and `out_neg` = 0 for any pixel and either negate value.
- R4: `out_vld` is high in the cycle after a clock edge that sampled `in_vld` high, and low in the cycle after an edge that sampled it low.
- R5: When `in_vld` is low at a clock edge, `out_mag` and `out_neg` keep their previous values.
- R6: While `rst_n` is low, `out_vld`, `out_mag` and `out_neg` are all 0.
- R7: The largest product, 21 times the maximum pixel (5355 for 8-bit pixels), appears without overflow on the `PIX_W+5`-bit magnitude.
- R8: Valid inputs on consecutive cycles each produce their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input strobe; the operands are sampled when it is high |
| in_pix | input | PIX_W | Unsigned pixel value |
| in_code | input | 3 | Coefficient select (0..6 valid, 7 unsupported) |
| in_neg | input | 1 | Negate the coefficient |
| out_vld | output | 1 | Result valid, one cycle after the input |
| out_mag | output | PIX_W+5 | Result magnitude |
| out_neg | output | 1 | Result sign (1 means negative) |

## Verification
All state sits in one output register. A wrong lane select, a wrong shift or a wrong sign conversion therefore shows at the ports in the cycle right after the input that caused it, either as a wrong magnitude or as a negative zero. A stale or corrupted register shows up in the next comparison, because the reference model checks every clock, including idle cycles where the outputs must hold. Running every code at the maximum pixel with both signs exposes any lane that is dropped or doubled, and any overflow of the magnitude width.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    localparam int unsigned CODE_W = 3;

    // Selection for the high lane (0, 8x or 16x)
    typedef enum logic [1:0] {
        HI_NONE = 2'd0,
        HI_X8   = 2'd1,
        HI_X16  = 2'd2
    } hi_sel_e;

    typedef struct packed {
        logic    lo_on;   // adds 1x pixel
        logic    mid_on;  // adds 4x pixel
        hi_sel_e hi_sel;  // adds 0, 8x or 16x pixel
    } lane_sel_t;

endpackage

// File: rtl/rcu_coef_decode.sv
module rcu_coef_decode
    import rcu_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output lane_sel_t         sel
);

    always_comb begin
        sel = '{lo_on: 1'b0, mid_on: 1'b0, hi_sel: HI_NONE};
        unique case (code)
            3'd0: sel.lo_on = 1'b1;                                  // 1
            3'd1: sel.mid_on = 1'b1;                                 // 4
            3'd2: begin sel.lo_on = 1'b1; sel.mid_on = 1'b1; end     // 5
            3'd3: sel.hi_sel = HI_X8;                                // 8
            3'd4: begin sel.lo_on = 1'b1; sel.hi_sel = HI_X8; end    // 9
            3'd5: begin sel.lo_on = 1'b1; sel.hi_sel = HI_X16; end   // 17
            3'd6: begin
                sel.lo_on  = 1'b1;
                sel.mid_on = 1'b1;
                sel.hi_sel = HI_X16;                                 // 21
            end
            default: ;                                               // unsupported: zero
        endcase
    end

endmodule

// File: rtl/rcu_lane_sum.sv
module rcu_lane_sum
    import rcu_pkg::*;
#(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned MAG_W = PIX_W + 5
) (
    input  logic [PIX_W-1:0] pix,
    input  lane_sel_t        sel,
    output logic [MAG_W-1:0] sum
);

    localparam int unsigned PAD_W = MAG_W - PIX_W;

    logic [MAG_W-1:0] x1;
    logic [MAG_W-1:0] x4;
    logic [MAG_W-1:0] x8;
    logic [MAG_W-1:0] x16;
    logic [MAG_W-1:0] lane_lo;
    logic [MAG_W-1:0] lane_mid;
    logic [MAG_W-1:0] lane_hi;

    // fixed shifts
    assign x1  = {{PAD_W{1'b0}}, pix};
    assign x4  = x1 << 2;
    assign x8  = x1 << 3;
    assign x16 = x1 << 4;

    always_comb begin
        lane_lo  = sel.lo_on  ? x1 : '0;
        lane_mid = sel.mid_on ? x4 : '0;
        unique case (sel.hi_sel)
            HI_X8:   lane_hi = x8;
            HI_X16:  lane_hi = x16;
            default: lane_hi = '0;
        endcase
    end

    assign sum = lane_lo + lane_mid + lane_hi;

endmodule

// File: rtl/rcu_sign_mag.sv
module rcu_sign_mag #(
    parameter int unsigned MAG_W = 13,
    parameter int unsigned SUM_W = MAG_W + 1
) (
    input  logic [SUM_W-1:0] val,   // two's complement
    output logic [MAG_W-1:0] mag,
    output logic             neg
);

    assign neg = val[SUM_W-1];
    assign mag = neg ? MAG_W'(~val + 1'b1) : MAG_W'(val);

endmodule

// File: rtl/rcu_shift_add.sv
module rcu_shift_add
    import rcu_pkg::*;
#(
    parameter  int unsigned PIX_W = 8,
    localparam int unsigned MAG_W = PIX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_neg,
    output logic              out_vld,
    output logic [MAG_W-1:0]  out_mag,
    output logic              out_neg
);

    localparam int unsigned SUM_W = MAG_W + 1;

    typedef struct packed {
        logic             vld;
        logic             neg;
        logic [MAG_W-1:0] mag;
    } state_t;

    lane_sel_t        sel;
    logic [MAG_W-1:0] lane_total;
    logic [SUM_W-1:0] ext_sum;
    logic [SUM_W-1:0] signed_sum;
    logic [MAG_W-1:0] blk_mag;
    logic             blk_neg;
    state_t           st_d;
    state_t           st_q;

    rcu_coef_decode u_dec (
        .code (in_code),
        .sel  (sel)
    );

    rcu_lane_sum #(
        .PIX_W (PIX_W),
        .MAG_W (MAG_W)
    ) u_lanes (
        .pix (in_pix),
        .sel (sel),
        .sum (lane_total)
    );

    assign ext_sum    = {1'b0, lane_total};
    assign signed_sum = in_neg ? (~ext_sum + 1'b1) : ext_sum;

    rcu_sign_mag #(
        .MAG_W (MAG_W),
        .SUM_W (SUM_W)
    ) u_sign (
        .val (signed_sum),
        .mag (blk_mag),
        .neg (blk_neg)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.mag = blk_mag;
            st_d.neg = blk_neg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_mag = st_q.mag;
    assign out_neg = st_q.neg;

endmodule

// File: rtl/rcu_shift_add_chk.sv
module rcu_shift_add_chk #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned MAG_W = PIX_W + 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [PIX_W-1:0] in_pix,
    input logic [2:0]       in_code,
    input logic             in_neg,
    input logic             out_vld,
    input logic [MAG_W-1:0] out_mag,
    input logic             out_neg
);

    localparam int unsigned MAX_PROD = 21 * ((1 << PIX_W) - 1);

    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r4_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_mag) && $stable(out_neg)));

    a_r2_no_negative_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mag == '0) |-> !out_neg);

    a_r3_unsupported_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_code == 3'd7) |=> (out_mag == '0 && !out_neg));

    a_r2_sign_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_neg && in_pix != '0 && in_code != 3'd7) |=> out_neg);

    a_r7_within_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_mag <= MAG_W'(MAX_PROD));

endmodule

bind rcu_shift_add rcu_shift_add_chk #(
    .PIX_W (PIX_W),
    .MAG_W (MAG_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_pix  (in_pix),
    .in_code (in_code),
    .in_neg  (in_neg),
    .out_vld (out_vld),
    .out_mag (out_mag),
    .out_neg (out_neg)
);

// File: tb/tb_rcu_shift_add.sv
module tb_rcu_shift_add;

    localparam int PIX_W = 8;
    localparam int MAG_W = PIX_W + 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_vld = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic [2:0]       in_code = '0;
    logic             in_neg = 1'b0;
    logic             out_vld;
    logic [MAG_W-1:0] out_mag;
    logic             out_neg;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rcu_shift_add #(.PIX_W(PIX_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_pix  (in_pix),
        .in_code (in_code),
        .in_neg  (in_neg),
        .out_vld (out_vld),
        .out_mag (out_mag),
        .out_neg (out_neg)
    );

    // Coefficients per R1; code 7 unsupported per R3
    function automatic int coef_of(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 4;
            3'd2: return 5;
            3'd3: return 8;
            3'd4: return 9;
            3'd5: return 17;
            3'd6: return 21;
            default: return 0;
        endcase
    endfunction

    // Behavioural reference: expected outputs after each edge
    int    exp_mag = 0;
    bit    exp_neg = 1'b0;
    bit    exp_vld = 1'b0;
    string exp_tag = "R6";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_mag <= 0; exp_neg <= 1'b0; exp_vld <= 1'b0; exp_tag <= "R6";
        end else begin
            exp_vld <= in_vld;
            if (in_vld) begin
                exp_mag <= coef_of(in_code) * int'(in_pix);
                exp_neg <= in_neg && (coef_of(in_code) * int'(in_pix) != 0);
                exp_tag <= (in_code == 3'd7) ? "R3" : (in_neg ? "R2" : "R1");
            end else begin
                exp_tag <= "R5";
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            check("R4", int'(out_vld), int'(exp_vld), "out_vld");
            check(exp_tag, int'(out_mag), exp_mag, "out_mag");
            check(exp_tag, int'(out_neg), int'(exp_neg), "out_neg");
        end
    end

    task automatic drive(input bit v, input int p, input int c, input bit n);
        @(negedge clk);
        in_vld  = v;
        in_pix  = PIX_W'(p);
        in_code = 3'(c);
        in_neg  = n;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R6: reset state, driving inputs that must not leak through
        in_vld = 1'b1; in_pix = 8'hFF; in_code = 3'd6; in_neg = 1'b1;
        repeat (3) @(negedge clk);
        check("R6", int'(out_vld), 0, "reset out_vld");
        check("R6", int'(out_mag), 0, "reset out_mag");
        check("R6", int'(out_neg), 0, "reset out_neg");
        in_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: every code at max pixel, both signs
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n < 2; n++) begin
                drive(1'b1, 255, c, n[0]);
            end
        end
        // R2: zero pixel with negate gives positive zero
        drive(1'b1, 0, 6, 1'b1);
        // R3: unsupported code with non-zero pixel
        drive(1'b1, 200, 7, 1'b1);
        drive(1'b0, 0, 0, 1'b0);

        // R7: largest product
        drive(1'b1, 255, 6, 1'b0);
        @(posedge clk); #1;
        check("R7", int'(out_mag), 5355, "max product");

        // R5: idle with changing inputs keeps the last result
        drive(1'b0, 17, 0, 1'b1);
        drive(1'b0, 3, 4, 1'b0);
        @(posedge clk); #1;
        check("R5", int'(out_mag), 5355, "held magnitude");

        // R8: back-to-back results in order
        drive(1'b1, 10, 1, 1'b0);
        @(posedge clk); #1;
        check("R8", int'(out_mag), 40, "first of pair");
        drive(1'b1, 10, 5, 1'b1);
        @(posedge clk); #1;
        check("R8", int'(out_mag), 170, "second of pair");
        check("R8", int'(out_neg), 1, "second of pair sign");

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            drive(($urandom % 4) != 0, int'($urandom % 256), int'($urandom % 8),
                  1'($urandom % 2));
        end
        drive(1'b0, 0, 0, 1'b0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule